// File: doc/BRIEF.md
# PHY Register Access Sequencer

This block is a hardware master for a 16-bit PHY register space that has no memory mapping. The only path into that space is a shared 20-bit control word that the block drives and a 17-bit status word that it reads. Each step of an access raises one request bit and waits for the PHY's acknowledge to go high. It then drops the request and waits for acknowledge to go low, a four-phase handshake, before the next step may begin.

A host pulses `start_i` for one cycle with a direction, an address and write data. The block first captures the address and then, for a write, captures the data and strobes the write. For a read it strobes the read and samples the returned data. It reports completion with a one-cycle `done_o` and, on failure, `err_o`. Acknowledge is synchronised through two flops before use. Each wait samples it once per interval of `SAMPLE_US` microseconds, and a wait gives up after `MAX_SAMPLES` samples.

Top module: `phy_seq`

## Requirements
- R1: After reset `ctrl_o` is all zero and `busy_o`, `done_o` and `err_o` are low.
- R2: In `ctrl_o`, bits [15:0] carry the address or data, bit 16 requests address capture, bit 17 requests data capture, bit 18 is the write strobe and bit 19 is the read strobe. In `sta_i`, bits [15:0] carry read data and bit 16 is acknowledge.
- R3: Every access starts with address capture. The address is driven alone, then together with bit 16 until acknowledge is seen high. The address is then driven alone until acknowledge is seen low.
- R4: A write then captures the data with bit 17 the same way, then raises bit 18 alone until acknowledge is seen high. It drives the data until acknowledge is seen low, so a write takes exactly three acknowledge pulses.
- R5: A read raises bit 19 alone until acknowledge is seen high and returns `sta_i[15:0]` from that sample on `rdata_o`. It drives an all-zero control word until acknowledge is seen low, so a read takes exactly two acknowledge pulses.
- R6: At most one of bits 19:16 of `ctrl_o` is set at any time. While a strobe is set, bits [15:0] are zero.
- R7: Acknowledge is compared after a two-flop synchroniser. Samples are taken every `CLK_MHZ*SAMPLE_US` cycles, the first one interval after a wait begins. If the expected level is missing at sample `MAX_SAMPLES`, the access ends with `done_o` and `err_o` high and `ctrl_o` returns to zero.
- R8: An acknowledge that reaches the expected level in time for the last allowed sample lets the access complete without error.
- R9: A `start_i` pulse while `busy_o` is high is ignored.
- R10: `done_o` is a one-cycle pulse during which `busy_o` is already low, and a `start_i` in that same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle command pulse |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | PHY register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout flag, valid with done |
| rdata_o | output | 16 | Read result, valid with done |
| ctrl_o | output | 20 | Control word to PHY |
| sta_i | input | 17 | Status word from PHY |

## Verification
Two pairs of events can fall in one cycle. The first is a fresh `start_i` landing in the same cycle as `done_o`. The bench raises start exactly in the cycle it sees done and judges the result by `busy_o` rising on the next edge and the second access returning correct data. The second is an acknowledge edge landing on the final sample of a wait, where success and timeout meet. A PHY model with a programmable response delay sets the edge just before and just after the tenth sample. Only the late case must report `err_o` and end with a zero control word.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  localparam int unsigned FLD_W       = 16;
  localparam int unsigned CAP_ADR_BIT = 16;
  localparam int unsigned CAP_DAT_BIT = 17;
  localparam int unsigned WR_BIT      = 18;
  localparam int unsigned RD_BIT      = 19;
  localparam int unsigned CTRL_W      = 20;
  localparam int unsigned ACK_BIT     = 16;
  localparam int unsigned STA_W       = 17;

  typedef enum logic [3:0] {
    S_IDLE, S_A_SET, S_A_CAP, S_A_REL,
    S_D_SET, S_D_CAP, S_D_REL,
    S_W_STB, S_W_REL,
    S_R_STB, S_R_REL
  } seq_state_e;
endpackage

// File: rtl/phy_seq_sync.sv
module phy_seq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/phy_seq_sampler.sv
module phy_seq_sampler #(
  parameter int unsigned TICK        = 250,
  parameter int unsigned MAX_SAMPLES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic active_i,
  input  logic ack_i,
  input  logic expect_i,
  output logic hit_o,
  output logic expire_o
);
  localparam int unsigned TW = (TICK > 1) ? $clog2(TICK) : 1;
  localparam int unsigned SW = $clog2(MAX_SAMPLES + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK - 1);
  localparam logic [SW-1:0] SMP_LAST  = SW'(MAX_SAMPLES - 1);

  logic [TW-1:0] tick_q;
  logic [SW-1:0] smp_q;
  logic          sample;

  assign sample   = active_i && (tick_q == '0);
  assign hit_o    = sample && (ack_i == expect_i);
  assign expire_o = sample && (ack_i != expect_i) && (smp_q == SMP_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= TICK_LAST;
      smp_q  <= '0;
    end else if (restart_i) begin
      tick_q <= TICK_LAST;
      smp_q  <= '0;
    end else if (active_i) begin
      if (tick_q == '0) begin
        tick_q <= TICK_LAST;
        smp_q  <= smp_q + 1'b1;
      end else begin
        tick_q <= tick_q - 1'b1;
      end
    end
  end

  // R7: never more than MAX_SAMPLES samples within one wait
  a_r7_sample_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (smp_q < SW'(MAX_SAMPLES)));
  // R7: samples are spaced by the interval
  a_r7_sample_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample && !restart_i) |=> (tick_q == TICK_LAST));
endmodule

// File: rtl/phy_seq.sv
module phy_seq
  import phy_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 250,
  parameter int unsigned SAMPLE_US   = 1,
  parameter int unsigned MAX_SAMPLES = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [FLD_W-1:0]  addr_i,
  input  logic [FLD_W-1:0]  wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [FLD_W-1:0]  rdata_o,
  output logic [CTRL_W-1:0] ctrl_o,
  input  logic [STA_W-1:0]  sta_i
);
  localparam int unsigned TICK = CLK_MHZ * SAMPLE_US;

  seq_state_e       st_q, st_d;
  logic             wr_q;
  logic [FLD_W-1:0] addr_q, data_q;
  logic             ack_s, waiting, want_hi, hit, expire;

  phy_seq_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (sta_i[ACK_BIT]), .q_o (ack_s)
  );

  always_comb begin
    waiting = 1'b0;
    want_hi = 1'b0;
    unique case (st_q)
      S_A_CAP, S_D_CAP, S_W_STB, S_R_STB: begin waiting = 1'b1; want_hi = 1'b1; end
      S_A_REL, S_D_REL, S_W_REL, S_R_REL: waiting = 1'b1;
      default: ;
    endcase
  end

  phy_seq_sampler #(.TICK(TICK), .MAX_SAMPLES(MAX_SAMPLES)) u_smp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (st_d != st_q),
    .active_i  (waiting),
    .ack_i     (ack_s),
    .expect_i  (want_hi),
    .hit_o     (hit),
    .expire_o  (expire)
  );

  always_comb begin
    st_d = st_q;
    if (expire) st_d = S_IDLE;
    else begin
      unique case (st_q)
        S_IDLE:  if (start_i) st_d = S_A_SET;
        S_A_SET: st_d = S_A_CAP;
        S_A_CAP: if (hit) st_d = S_A_REL;
        S_A_REL: if (hit) st_d = wr_q ? S_D_SET : S_R_STB;
        S_D_SET: st_d = S_D_CAP;
        S_D_CAP: if (hit) st_d = S_D_REL;
        S_D_REL: if (hit) st_d = S_W_STB;
        S_W_STB: if (hit) st_d = S_W_REL;
        S_W_REL: if (hit) st_d = S_IDLE;
        S_R_STB: if (hit) st_d = S_R_REL;
        S_R_REL: if (hit) st_d = S_IDLE;
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      st_q   <= st_d;
      done_o <= 1'b0;
      if (st_q == S_IDLE && start_i) begin
        wr_q   <= wr_i;
        addr_q <= addr_i;
        data_q <= wdata_i;
        err_o  <= 1'b0;
      end
      if (st_q == S_R_STB && hit) rdata_o <= sta_i[FLD_W-1:0];
      if (expire) begin
        done_o <= 1'b1;
        err_o  <= 1'b1;
      end else if (hit && (st_q == S_W_REL || st_q == S_R_REL)) begin
        done_o <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrl_o = '0;
    unique case (st_q)
      S_A_SET, S_A_REL:         ctrl_o[FLD_W-1:0] = addr_q;
      S_A_CAP: begin            ctrl_o[FLD_W-1:0] = addr_q; ctrl_o[CAP_ADR_BIT] = 1'b1; end
      S_D_SET, S_D_REL, S_W_REL: ctrl_o[FLD_W-1:0] = data_q;
      S_D_CAP: begin            ctrl_o[FLD_W-1:0] = data_q; ctrl_o[CAP_DAT_BIT] = 1'b1; end
      S_W_STB:                  ctrl_o[WR_BIT] = 1'b1;
      S_R_STB:                  ctrl_o[RD_BIT] = 1'b1;
      default: ;
    endcase
  end

  assign busy_o = (st_q != S_IDLE);

  a_r6_one_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ctrl_o[RD_BIT:CAP_ADR_BIT]));
  a_r6_strobe_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[WR_BIT] || ctrl_o[RD_BIT]) |-> (ctrl_o[FLD_W-1:0] == '0));
  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_cmd_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && busy_o) |-> ($stable(addr_q) && $stable(data_q) && $stable(wr_q)));
  a_r7_zero_after_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (ctrl_o == '0));
  a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ctrl_o == '0));
endmodule

// File: tb/phy_seq_tb.sv
module phy_seq_tb;
  localparam int unsigned T   = 250;
  localparam int unsigned LIM = 10 * T;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic        busy, done, err;
  logic [15:0] rdata;
  logic [19:0] ctrl;
  logic [16:0] sta;

  int unsigned tests = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  phy_seq u_dut (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .wr_i (wr),
    .addr_i (addr), .wdata_i (wdata), .busy_o (busy), .done_o (done),
    .err_o (err), .rdata_o (rdata), .ctrl_o (ctrl), .sta_i (sta)
  );

  // PHY model
  logic [15:0] mem [16];
  logic        ack = 1'b0, hang = 1'b0;
  logic [15:0] sdat = '0, lat_addr = '0, lat_data = '0;
  int unsigned dly = 3, dcnt = 0, pulses = 0;
  wire         req = |ctrl[19:16];
  assign sta = {ack, sdat};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if ((req && !ack && !hang) || (!req && ack)) begin
      if (dcnt >= dly) begin
        dcnt <= 0;
        ack  <= req;
        if (req) begin
          pulses <= pulses + 1;
          if (ctrl[16]) lat_addr <= ctrl[15:0];
          if (ctrl[17]) lat_data <= ctrl[15:0];
          if (ctrl[18]) mem[lat_addr[3:0]] <= lat_data;
          if (ctrl[19]) sdat <= mem[lat_addr[3:0]];
        end
      end else dcnt <= dcnt + 1;
    end else dcnt <= 0;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic launch(input bit w, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    start = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  // waits for done; cycles counted from the start edge
  task automatic wait_done(output int unsigned n);
    n = 1;
    while (!done && n < 4 * LIM * 4) begin
      @(negedge clk);
      n++;
    end
  endtask

  logic [48:0] vecs [8];
  initial begin
    // {wr, addr, data/expected}
    vecs[0] = {1'b1, 16'h0003, 16'hA5C3, 16'h0};
    vecs[1] = {1'b0, 16'h0003, 16'hA5C3, 16'h0};
    vecs[2] = {1'b1, 16'h0000, 16'hFFFF, 16'h0};
    vecs[3] = {1'b1, 16'h100F, 16'h0001, 16'h0};
    vecs[4] = {1'b0, 16'h0000, 16'hFFFF, 16'h0};
    vecs[5] = {1'b0, 16'h100F, 16'h0001, 16'h0};
    vecs[6] = {1'b1, 16'h0003, 16'h0000, 16'h0};
    vecs[7] = {1'b0, 16'h0003, 16'h0000, 16'h0};
  end

  initial begin
    while (cyc < 200000) @(negedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, 200000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned n;
    for (int i = 0; i < 16; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    chk(ctrl == 0 && !busy && !done && !err, "R1 reset", {ctrl, busy, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl == 0 && !busy, "R1 after release", {ctrl, busy}, 0);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 8; i++) begin
      bit w = vecs[i][48];
      logic [15:0] a = vecs[i][47:32];
      logic [15:0] d = vecs[i][31:16];
      pulses = 0;
      launch(w, a, d);
      chk(busy, "R3 busy after start", busy, 1);
      wait_done(n);
      chk(done && !err, "R4/R5 completes", {done, err}, 2'b10);
      chk(lat_addr == a, "R2/R3 address field", lat_addr, a);
      if (w) begin
        chk(pulses == 3, "R4 three ack pulses", pulses, 3);
        chk(lat_data == d, "R2/R4 data field", lat_data, d);
      end else begin
        chk(pulses == 2, "R5 two ack pulses", pulses, 2);
        chk(rdata == d, "R5 read data", rdata, d);
        chk(ctrl == 0 && !ack, "R5 ends zero and ack low", {ctrl, ack}, 0);
      end
      @(negedge clk);
      chk(!done, "R10 done one cycle", done, 0);
    end

    // R9: second start while busy ignored
    launch(1'b1, 16'h0005, 16'h1111);
    @(negedge clk);
    start = 1'b1; wr = 1'b1; addr = 16'h0006; wdata = 16'h2222;
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    @(negedge clk);
    chk(!busy, "R9 no extra access", busy, 0);
    chk(mem[6] == 16'h0 && mem[5] == 16'h1111, "R9 ignored command", {mem[6], mem[5]}, 32'h0000_1111);

    // R10: start in the done cycle
    launch(1'b0, 16'h0005, 16'h0);
    wait_done(n);
    start = 1'b1; wr = 1'b0; addr = 16'h0003; wdata = 16'h0;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R10 start in done cycle accepted", busy, 1);
    wait_done(n);
    chk(!err && rdata == 16'h0000, "R10 back-to-back result", {err, rdata}, 0);

    // R7: no acknowledge at all
    hang = 1'b1;
    launch(1'b0, 16'h0001, 16'h0);
    wait_done(n);
    chk(done && err, "R7 timeout flagged", {done, err}, 2'b11);
    chk(n >= LIM - 2 && n <= LIM + 3, "R7 timeout window", n, LIM);
    chk(ctrl == 0, "R7 ctrl zero after timeout", ctrl, 0);
    hang = 1'b0;
    @(negedge clk);

    // R8: ack just in time for the last sample
    dly = LIM - 8;
    mem[2] = 16'h5A5A;
    launch(1'b0, 16'h0002, 16'h0);
    wait_done(n);
    chk(done && !err, "R8 last-sample success", {done, err}, 2'b10);
    chk(rdata == 16'h5A5A, "R8 read data", rdata, 16'h5A5A);

    // R7: ack one step late
    dly = LIM + 2;
    launch(1'b1, 16'h0002, 16'h0BAD);
    wait_done(n);
    chk(done && err, "R7 late ack times out", {done, err}, 2'b11);
    chk(ctrl == 0 && mem[2] == 16'h5A5A, "R7 no write after timeout", {ctrl, mem[2]}, 16'h5A5A);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule